// File: doc/BRIEF.md
# Two-Stage Watchdog Reset Controller

This block watches for a periodic service write from software and escalates in two steps when it stops coming. A primary counter runs while the watchdog is armed. When it reaches its programmed limit, the block emits a one-cycle time-out interrupt, latches a pending flag and starts a secondary grace counter. If software acknowledges the interrupt, the grace counter stops and the primary count starts again from zero. If the grace counter reaches its own limit first, the block raises a system reset request, held for a fixed number of cycles, and drives the active-low external reset pin with it.

The control register also gives software a one-shot system reset trigger and a set/release pair of write-one strobes for the external reset pin. All access goes through a plain synchronous register port in one clock domain. Writes take effect at the clock edge where `wr_en` is sampled high, and reads are combinational from `addr`. No data stream crosses the block's edge, so no valid/ready handshake is used and the port never applies back-pressure. Address map: 0 control, 1 primary limit, 2 grace limit, 3 acknowledge, 4 service, 5 primary count (read), 6 grace count (read).

Top module: `wdog_reset_ctrl`

## Requirements
- R1: With the arm bit (control bit 0) clear, both counters read zero and no interrupt pulse is produced.
- R2: After the control write that sets the arm bit, `irq_pulse` is high for exactly one cycle, LIMIT+1 cycles after that write edge, where LIMIT is the value at address 1.
- R3: The pending flag (control read bit 2) is set together with the pulse and stays set until it is acknowledged. While it is set, the primary counter is stopped.
- R4: Writing the service key (0x0000A5C3) to address 4 while the block is armed and not pending clears the primary counter. Any other value, or any service write while pending, has no effect.
- R5: Writing 1 in bit 0 to address 3 while pending clears the flag and the grace counter. The next pulse then follows LIMIT+1 cycles after that write edge.
- R6: If no acknowledge arrives, `sys_rst_req` rises GLIM+1 cycles after the pulse, where GLIM is the value at address 2.
- R7: `sys_rst_req` stays high for exactly 16 cycles, and `ext_rst_n` is low for as long as it is high.
- R8: When an acknowledge write falls in the same cycle as the grace counter reaching its limit, the reset still occurs.
- R9: Writing 1 to control bit 4 raises `sys_rst_req` at the write edge.
- R10: Control bit 5 written as 1 drives `ext_rst_n` low, and bit 6 written as 1 releases it; both are strobes. When both are written together, the pin is driven low. Control read bit 3 reflects the held state, and `sys_rst_req` is not affected.
- R11: When a reset request starts, the control bits, the counters and the pending flag return to zero and both limits return to all ones. Writes made while the request is active are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` |
| irq_pulse | output | 1 | One-cycle time-out interrupt |
| sys_rst_req | output | 1 | System reset request, held for 16 cycles |
| ext_rst_n | output | 1 | Active-low external reset pin |

## Verification
The collision that matters is between an acknowledge write and the grace counter reaching its limit. The bench counts cycles from the observed interrupt pulse and places the acknowledge write so that its edge lands on the limit cycle, where a reset must follow. It then repeats the write one cycle earlier, where no reset may follow and the flag must clear. The same counting method also sets a service write against the primary count and a set/release write pair against each other, and every outcome is judged from the pins and from register reads.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 3'd0,
    REG_WLIM = 3'd1,
    REG_GLIM = 3'd2,
    REG_ACK  = 3'd3,
    REG_SVC  = 3'd4,
    REG_WCNT = 3'd5,
    REG_GCNT = 3'd6
  } reg_sel_e;

  // control register bit positions
  localparam int B_ARM     = 0;
  localparam int B_PEND    = 2;
  localparam int B_EXT     = 3;
  localparam int B_SWRST   = 4;
  localparam int B_EXT_SET = 5;
  localparam int B_EXT_REL = 6;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter int          CNT_W   = 16,
  parameter logic [31:0] SVC_KEY = 32'h0000_A5C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hold,
  input  logic              soft_clr,
  output logic              arm,
  output logic              ext_hold,
  output logic [CNT_W-1:0]  wd_limit,
  output logic [CNT_W-1:0]  gr_limit,
  output logic              ack_stb,
  output logic              svc_stb,
  output logic              swrst_stb
);
  reg_sel_e sel;
  logic     wr_ok, ctrl_wr, ext_set, ext_rel;

  assign sel       = reg_sel_e'(addr);
  assign wr_ok     = wr_en && !hold;
  assign ctrl_wr   = wr_ok && (sel == REG_CTRL);
  assign ext_set   = ctrl_wr && wr_data[B_EXT_SET];
  assign ext_rel   = ctrl_wr && wr_data[B_EXT_REL];
  assign swrst_stb = ctrl_wr && wr_data[B_SWRST];
  assign ack_stb   = wr_ok && (sel == REG_ACK) && wr_data[0];
  assign svc_stb   = wr_ok && (sel == REG_SVC) && (wr_data == DATA_W'(SVC_KEY));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm      <= 1'b0;
      ext_hold <= 1'b0;
      wd_limit <= '1;
      gr_limit <= '1;
    end else if (soft_clr) begin
      arm      <= 1'b0;
      ext_hold <= 1'b0;
      wd_limit <= '1;
      gr_limit <= '1;
    end else begin
      if (ctrl_wr) arm <= wr_data[B_ARM];
      if (ext_set)      ext_hold <= 1'b1;
      else if (ext_rel) ext_hold <= 1'b0;
      if (wr_ok && sel == REG_WLIM) wd_limit <= wr_data[CNT_W-1:0];
      if (wr_ok && sel == REG_GLIM) gr_limit <= wr_data[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/wdog_stage.sv
module wdog_stage #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             restart,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  assign hit = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr || restart)    cnt <= '0;
    else if (hit)               cnt <= '0;
    else if (run)               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdog_rst_stretch.sv
module wdog_rst_stretch #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic req
);
  localparam int W = $clog2(HOLD + 1);
  logic [W-1:0] left;

  assign req = (left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                left <= '0;
    else if (trigger && !req)  left <= W'(HOLD);
    else if (req)              left <= left - 1'b1;
  end
endmodule

// File: rtl/wdog_reset_ctrl.sv
module wdog_reset_ctrl
  import wdog_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          CNT_W    = 16,
  parameter int          RST_HOLD = 16,
  parameter logic [31:0] SVC_KEY  = 32'h0000_A5C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_pulse,
  output logic              sys_rst_req,
  output logic              ext_rst_n
);
  logic             arm, ext_hold, ack_stb, svc_stb, swrst_stb;
  logic [CNT_W-1:0] wd_limit, gr_limit, wd_cnt, gr_cnt;
  logic             hit0, hit1, pend_q, soft_clr, trigger;
  logic             svc_ok, ack_ok, timeout, stage_clr;

  wdog_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SVC_KEY(SVC_KEY)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .hold(sys_rst_req), .soft_clr(soft_clr), .arm(arm), .ext_hold(ext_hold),
    .wd_limit(wd_limit), .gr_limit(gr_limit), .ack_stb(ack_stb),
    .svc_stb(svc_stb), .swrst_stb(swrst_stb)
  );

  assign stage_clr = soft_clr || !arm;
  assign svc_ok    = svc_stb && arm && !pend_q;
  assign ack_ok    = ack_stb && pend_q && !hit1;
  assign timeout   = hit0 && !svc_ok;
  assign trigger   = hit1 || swrst_stb;
  assign soft_clr  = sys_rst_req || trigger;

  wdog_stage #(.CNT_W(CNT_W)) prim_i (
    .clk(clk), .rst_n(rst_n), .clr(stage_clr), .restart(svc_ok),
    .run(arm && !pend_q), .limit(wd_limit), .cnt(wd_cnt), .hit(hit0)
  );

  wdog_stage #(.CNT_W(CNT_W)) grace_i (
    .clk(clk), .rst_n(rst_n), .clr(stage_clr), .restart(ack_ok),
    .run(pend_q), .limit(gr_limit), .cnt(gr_cnt), .hit(hit1)
  );

  wdog_rst_stretch #(.HOLD(RST_HOLD)) stretch_i (
    .clk(clk), .rst_n(rst_n), .trigger(trigger), .req(sys_rst_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      irq_pulse <= timeout && !soft_clr;
      if (stage_clr)    pend_q <= 1'b0;
      else if (timeout) pend_q <= 1'b1;
      else if (ack_ok)  pend_q <= 1'b0;
    end
  end

  assign ext_rst_n = !(ext_hold || sys_rst_req);

  always_comb begin
    rd_data = '0;
    case (reg_sel_e'(addr))
      REG_CTRL: begin
        rd_data[B_ARM]  = arm;
        rd_data[B_PEND] = pend_q;
        rd_data[B_EXT]  = ext_hold;
      end
      REG_WLIM: rd_data = DATA_W'(wd_limit);
      REG_GLIM: rd_data = DATA_W'(gr_limit);
      REG_WCNT: rd_data = DATA_W'(wd_cnt);
      REG_GCNT: rd_data = DATA_W'(gr_cnt);
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/wdog_reset_ctrl_chk.sv
module wdog_reset_ctrl_chk #(
  parameter int HOLD = 16
) (
  input logic clk,
  input logic rst_n,
  input logic irq_pulse,
  input logic sys_rst_req,
  input logic ext_rst_n,
  input logic pend,
  input logic hit1
);
  localparam int W = $clog2(HOLD + 1) + 1;
  logic [W-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run_len <= '0;
    else if (sys_rst_req) run_len <= run_len + 1'b1;
    else                  run_len <= '0;
  end

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  a_r3_pulse_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> pend);

  a_r7_pin_low_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> !ext_rst_n);

  a_r7_hold_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_req) |-> (run_len == W'(HOLD)));

  a_r8_expiry_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit1 |=> sys_rst_req);

  a_r11_clean_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_req) |-> (ext_rst_n && !pend));
endmodule

bind wdog_reset_ctrl wdog_reset_ctrl_chk #(.HOLD(RST_HOLD)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_pulse(irq_pulse), .sys_rst_req(sys_rst_req),
  .ext_rst_n(ext_rst_n), .pend(pend_q), .hit1(hit1)
);

// File: tb/wdog_reset_ctrl_tb_top.sv
`timescale 1ns/1ps
module wdog_reset_ctrl_tb_top;
  localparam int CW   = 8;
  localparam int HOLD = 16;
  localparam logic [31:0] KEY = 32'h0000_A5C3;

  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic        irq_pulse, sys_rst_req, ext_rst_n;
  int          n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  wdog_reset_ctrl #(.CNT_W(CW), .RST_HOLD(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq_pulse(irq_pulse), .sys_rst_req(sys_rst_req),
    .ext_rst_n(ext_rst_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; sampled at the next posedge; returns at the following negedge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr = a; #0.1; v = rd_data;
  endtask

  task automatic wait_irq(output int k);
    k = 0;
    while (!irq_pulse && k < 1000) begin @(negedge clk); k++; end
  endtask

  task automatic wait_req(output int k);
    k = 0;
    while (!sys_rst_req && k < 1000) begin @(negedge clk); k++; end
  endtask

  // measure the request width; pin must stay low throughout
  task automatic drain_req(input string req);
    int w = 0;
    bit pin_ok = 1'b1;
    while (sys_rst_req && w < 100) begin
      if (ext_rst_n) pin_ok = 1'b0;
      @(negedge clk); w++;
    end
    chk(w == HOLD, req, w, HOLD);
    chk(pin_ok, "R7 pin low", 0, 1);
  endtask

  task automatic check_defaults(input string req);
    logic [31:0] v;
    rd(3'd0, v); chk(v == 0, req, v, 0);
    rd(3'd1, v); chk(v == 32'hFF, req, v, 32'hFF);
    rd(3'd2, v); chk(v == 32'hFF, req, v, 32'hFF);
    rd(3'd5, v); chk(v == 0, req, v, 0);
    rd(3'd6, v); chk(v == 0, req, v, 0);
  endtask

  initial begin
    #(5ns * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int k;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_defaults("R11 reset state");
    chk(ext_rst_n && !sys_rst_req && !irq_pulse, "R11 outputs idle", 0, 1);

    // R1: disarmed watchdog stays idle
    wr(3'd1, 32'd2);
    seen = 1'b0;
    repeat (20) begin @(negedge clk); if (irq_pulse) seen = 1'b1; end
    chk(!seen, "R1 no pulse disarmed", seen, 0);
    rd(3'd5, v); chk(v == 0, "R1 counter idle", v, 0);

    // R2/R3/R6/R7/R11: sweep of both limits
    for (int l0 = 0; l0 <= 4; l0++) begin
      for (int l1 = 0; l1 <= 3; l1++) begin
        wr(3'd1, l0);
        wr(3'd2, l1);
        wr(3'd0, 32'h1);
        wait_irq(k);
        chk(k == l0 + 1, "R2 time-out delay", k, l0 + 1);
        rd(3'd0, v); chk(v[2], "R3 pending set", v, 4);
        @(negedge clk);
        chk(!irq_pulse, "R2 one-cycle pulse", irq_pulse, 0);
        rd(3'd5, v); chk(v == 0, "R3 primary stopped", v, 0);
        if (l1 > 0) begin
          rd(3'd0, v); chk(v[2], "R3 pending holds", v, 4);
        end
        k = 1;
        while (!sys_rst_req && k < 1000) begin @(negedge clk); k++; end
        chk(k == l1 + 1, "R6 grace delay", k, l1 + 1);
        drain_req("R7 hold width");
        check_defaults("R11 after watchdog reset");
      end
    end

    // R4: service key keeps the watchdog quiet
    wr(3'd1, 32'd3);
    wr(3'd0, 32'h1);
    seen = 1'b0;
    repeat (15) begin
      wr(3'd4, KEY);
      if (irq_pulse) seen = 1'b1;
      @(negedge clk);
      if (irq_pulse) seen = 1'b1;
    end
    chk(!seen, "R4 key service", seen, 0);
    // R4: wrong key ignored
    wr(3'd4, 32'h0000_1234);
    k = 1;
    while (!irq_pulse && k < 1000) begin @(negedge clk); k++; end
    chk(k <= 4, "R4 wrong key ignored", k, 4);
    // R5: acknowledge restarts the primary count
    wr(3'd3, 32'h1);
    rd(3'd0, v); chk(!v[2], "R5 pending cleared", v, 1);
    wait_irq(k);
    chk(k == 4, "R5 restart delay", k, 4);
    // R4: service while pending ignored (grace limit still 0xFF)
    wr(3'd4, KEY);
    rd(3'd6, v); chk(v == 1, "R4 service ignored when pending", v, 1);
    @(negedge clk);
    rd(3'd6, v); chk(v == 2, "R4 grace keeps counting", v, 2);
    wr(3'd0, 32'h10);
    drain_req("R9 hold width");

    // R8: acknowledge on the limit cycle, then one cycle earlier
    wr(3'd1, 32'd1);
    wr(3'd2, 32'd3);
    wr(3'd0, 32'h1);
    wait_irq(k);
    repeat (3) @(negedge clk);
    wr(3'd3, 32'h1);
    chk(sys_rst_req, "R8 reset wins over acknowledge", sys_rst_req, 1);
    drain_req("R8 hold width");
    wr(3'd1, 32'd1);
    wr(3'd2, 32'd3);
    wr(3'd0, 32'h1);
    wait_irq(k);
    repeat (2) @(negedge clk);
    wr(3'd3, 32'h1);
    rd(3'd0, v);
    chk(!sys_rst_req && !v[2], "R5 early acknowledge accepted", v, 1);
    seen = 1'b0;
    repeat (5) begin @(negedge clk); if (sys_rst_req) seen = 1'b1; end
    chk(!seen, "R5 no reset after acknowledge", seen, 0);
    wr(3'd0, 32'h0);

    // R9: software reset, writes ignored while active (R11)
    wr(3'd0, 32'h10);
    chk(sys_rst_req, "R9 software reset", sys_rst_req, 1);
    wr(3'd1, 32'd3);
    while (sys_rst_req) @(negedge clk);
    rd(3'd1, v); chk(v == 32'hFF, "R11 write ignored during reset", v, 32'hFF);

    // R10: external pin strobes
    wr(3'd0, 32'h20);
    rd(3'd0, v);
    chk(!ext_rst_n && !sys_rst_req && v[3], "R10 pin asserted", v, 8);
    wr(3'd0, 32'h0);
    chk(!ext_rst_n, "R10 strobe not a level", ext_rst_n, 0);
    wr(3'd0, 32'h40);
    rd(3'd0, v);
    chk(ext_rst_n && !v[3], "R10 pin released", v, 0);
    wr(3'd0, 32'h60);
    chk(!ext_rst_n, "R10 assert wins", ext_rst_n, 0);
    wr(3'd0, 32'h40);
    chk(ext_rst_n, "R10 release again", ext_rst_n, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule